// File: doc/BRIEF.md
# Serial Memory Bus Write Target

This block is the target side of a two-wire serial memory bus, limited to write transfers. It watches the clock and data lines, which arrive already synchronised to the system clock, and finds Start and Stop conditions. After a Start it shifts in a device select byte, then a high and a low address byte, then any number of data bytes. It pulls the data line low to acknowledge each byte that it accepts.

Every data byte is passed to a downstream page buffer as a one-cycle beat. The beat carries the byte, its 16-bit address and a write-enable flag. The address advances inside a 64-byte page. A separate pulse tells the write engine to commit the page. The pulse is raised only when the Stop arrives in the slot directly after an acknowledged data byte. An external write-control input refuses data bytes. While the write engine reports busy, the block stays off the bus entirely.

Top module: `eep_wr_slave`

## Requirements
- R1: A device select byte is acknowledged only when its upper seven bits equal the device address (default 7'h50) and its lowest bit (read/write) is 0. On any other value the target gives NoAck and acknowledges no further byte until the next Start.
- R2: After an accepted device select, the next two bytes are acknowledged. The first gives address bits 15..8 and the second gives bits 7..0 of the first data byte's address.
- R3: Each data byte produces a one-cycle pulse on byte_valid_o, with the byte on byte_data_o and its address on byte_addr_o. Each following byte's address is the previous one plus 1 in bits 5..0, wrapping from 63 to 0. Bits 15..6 do not change.
- R4: While wc_i is low, each data byte is acknowledged and reported with byte_we_o = 1.
- R5: While wc_i is high, each data byte gets NoAck and is reported with byte_we_o = 0. A Stop after such a byte raises no commit.
- R6: A Stop in the slot after the acknowledge clock of an acknowledged data byte gives exactly one pulse on commit_o.
- R7: A Stop at any other point, such as after the address bytes or part way through a data byte, gives no commit pulse.
- R8: A repeated Start abandons the transfer in progress without a commit, and the transfer that follows is decoded from its device select byte.
- R9: While busy_i is high, sda_oe_o stays low from the next cycle on, and even the block's own device select gets no acknowledge.
- R10: The acknowledge is driven during the low phase that follows the eighth clock. It holds through the ninth clock and is released after the ninth clock falls.
- R11: After reset, sda_oe_o, byte_valid_o and commit_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock level, synchronised |
| sda_i | input | 1 | Bus data level, synchronised (wired-AND line) |
| wc_i | input | 1 | Write control; high refuses data bytes |
| busy_i | input | 1 | Write engine busy; block keeps off the bus |
| sda_oe_o | output | 1 | Pull the data line low (acknowledge) |
| byte_valid_o | output | 1 | One-cycle pulse per received data byte |
| byte_addr_o | output | 16 | Address of the reported byte |
| byte_data_o | output | 8 | Reported data byte |
| byte_we_o | output | 1 | Byte may be written (write control was low) |
| commit_o | output | 1 | One-cycle pulse starting the write cycle |

## Verification
The bench sends all 256 device select values. A decoder that ignored the read/write bit, or compared the wrong bit field, would acknowledge some foreign or read codes. It writes from 1 to 4 bytes at start addresses that sit at a page edge and at the top of the address space. A counter that carried into bits 15..6 or stopped at the page edge would report the wrong addresses. Stops are placed after the address bytes, part way through a data byte, and after refused bytes, and a repeated Start is placed just after an acknowledged byte. A design that commits on any Stop would give extra commit pulses. The bench also samples the acknowledge before, during and after the ninth clock, and holds busy during a transfer, to catch an acknowledge that comes in the wrong phase or while busy.

// File: rtl/eep_wr_pkg.sv
package eep_wr_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 16;
    localparam int SLOT_W = 4;

    // bit slot counter values inside one byte frame
    localparam logic [SLOT_W-1:0] SLOT_ACK   = 4'd8;  // eight bits shifted, ack clock next
    localparam logic [SLOT_W-1:0] SLOT_LAST  = 4'd9;  // ack clock seen
    localparam logic [SLOT_W-1:0] SLOT_TENTH = 4'd1;  // first clock after an ack

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_DATA
    } wr_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
    } bus_ev_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
        logic              we;
    } wr_beat_t;

    // address of the next byte: only the low page bits advance, with wrap
    function automatic logic [ADDR_W-1:0] page_next(input logic [ADDR_W-1:0] a,
                                                    input int unsigned page_w);
        logic [ADDR_W-1:0] inc;
        logic [ADDR_W-1:0] res;
        inc = a + 1'b1;
        for (int i = 0; i < ADDR_W; i++) begin
            res[i] = (i < int'(page_w)) ? inc[i] : a[i];
        end
        return res;
    endfunction

    function automatic logic select_ok(input logic [BYTE_W-1:0] b,
                                       input logic [6:0]        dev);
        return (b[7:1] == dev) && !b[0];
    endfunction

endpackage

// File: rtl/eep_wr_edge.sv
module eep_wr_edge
    import eep_wr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev_o
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev_o.rise  = !scl_q && scl_i;
        ev_o.fall  = scl_q && !scl_i;
        ev_o.start = scl_q && scl_i && sda_q && !sda_i;
        ev_o.stop  = scl_q && scl_i && !sda_q && sda_i;
    end

    // a clock edge is never reported on two consecutive cycles
    p_edge_single_r10: assert property (@(posedge clk) disable iff (rst)
        (ev_o.rise || ev_o.fall) |=> !(ev_o.rise || ev_o.fall));

endmodule

// File: rtl/eep_wr_shift.sv
module eep_wr_shift
    import eep_wr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  bus_ev_t           ev,
    input  logic              sda_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic [SLOT_W-1:0] slot_o,
    output logic              byte_done_o,
    output logic              ack_end_o
);

    logic [BYTE_W-1:0] shreg;
    logic [SLOT_W-1:0] slot;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            shreg <= '0;
            slot  <= '0;
        end else if (ev.rise) begin
            if (slot < SLOT_ACK) begin
                shreg <= {shreg[BYTE_W-2:0], sda_i};
            end
            if (slot != SLOT_LAST) begin
                slot <= slot + 1'b1;
            end
        end else if (ev.fall && slot == SLOT_LAST) begin
            slot <= '0;
        end
    end

    assign byte_o      = shreg;
    assign slot_o      = slot;
    assign byte_done_o = ev.fall && (slot == SLOT_ACK);
    assign ack_end_o   = ev.fall && (slot == SLOT_LAST);

    p_slot_range_r10: assert property (@(posedge clk) disable iff (rst)
        slot <= SLOT_LAST);

    p_done_then_ack_r10: assert property (@(posedge clk) disable iff (rst)
        byte_done_o |=> !byte_done_o && !ack_end_o);

endmodule

// File: rtl/eep_wr_slave.sv
module eep_wr_slave
    import eep_wr_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR = 7'h50,
    parameter int unsigned PAGE_W   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              wc_i,
    input  logic              busy_i,
    output logic              sda_oe_o,
    output logic              byte_valid_o,
    output logic [ADDR_W-1:0] byte_addr_o,
    output logic [BYTE_W-1:0] byte_data_o,
    output logic              byte_we_o,
    output logic              commit_o
);

    bus_ev_t           ev;
    logic [BYTE_W-1:0] rx_byte;
    logic [SLOT_W-1:0] slot;
    logic              byte_done;
    logic              ack_end;

    wr_state_e         state;
    logic [ADDR_W-1:0] addr_q;
    logic              ack_q;
    logic              data_acked_q;
    wr_beat_t          beat_q;
    logic              beat_vld_q;
    logic              commit_q;

    eep_wr_edge u_edge (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    eep_wr_shift u_shift (
        .clk         (clk),
        .rst         (rst),
        .clear       (ev.start || ev.stop),
        .ev          (ev),
        .sda_i       (sda_i),
        .byte_o      (rx_byte),
        .slot_o      (slot),
        .byte_done_o (byte_done),
        .ack_end_o   (ack_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= ST_IDLE;
            addr_q       <= '0;
            ack_q        <= 1'b0;
            data_acked_q <= 1'b0;
            beat_q       <= '0;
            beat_vld_q   <= 1'b0;
            commit_q     <= 1'b0;
        end else begin
            beat_vld_q <= 1'b0;
            commit_q   <= 1'b0;
            if (busy_i) begin
                state        <= ST_IDLE;
                ack_q        <= 1'b0;
                data_acked_q <= 1'b0;
            end else if (ev.start) begin
                state        <= ST_DEVSEL;
                ack_q        <= 1'b0;
                data_acked_q <= 1'b0;
            end else if (ev.stop) begin
                if (state == ST_DATA && data_acked_q && slot == SLOT_TENTH) begin
                    commit_q <= 1'b1;
                end
                state        <= ST_IDLE;
                ack_q        <= 1'b0;
                data_acked_q <= 1'b0;
            end else begin
                if (ack_end) begin
                    ack_q <= 1'b0;
                end
                if (byte_done) begin
                    unique case (state)
                        ST_DEVSEL: begin
                            if (select_ok(rx_byte, DEV_ADDR)) begin
                                ack_q <= 1'b1;
                                state <= ST_ADDR_HI;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                        ST_ADDR_HI: begin
                            ack_q                         <= 1'b1;
                            addr_q[ADDR_W-1:BYTE_W]       <= rx_byte;
                            state                         <= ST_ADDR_LO;
                        end
                        ST_ADDR_LO: begin
                            ack_q               <= 1'b1;
                            addr_q[BYTE_W-1:0]  <= rx_byte;
                            state               <= ST_DATA;
                        end
                        ST_DATA: begin
                            beat_vld_q   <= 1'b1;
                            beat_q.addr  <= addr_q;
                            beat_q.data  <= rx_byte;
                            beat_q.we    <= !wc_i;
                            ack_q        <= !wc_i;
                            data_acked_q <= !wc_i;
                            addr_q       <= page_next(addr_q, PAGE_W);
                        end
                        default: begin
                        end
                    endcase
                end
            end
        end
    end

    assign sda_oe_o     = ack_q;
    assign byte_valid_o = beat_vld_q;
    assign byte_addr_o  = beat_q.addr;
    assign byte_data_o  = beat_q.data;
    assign byte_we_o    = beat_q.we;
    assign commit_o     = commit_q;

    p_ack_after_byte_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe_o) |-> $past(byte_done));

    p_busy_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> !sda_oe_o);

    p_we_follows_wc_r4: assert property (@(posedge clk) disable iff (rst)
        byte_valid_o |-> (byte_we_o == !$past(wc_i)));

    p_commit_on_stop_r6: assert property (@(posedge clk) disable iff (rst)
        commit_o |-> $past(ev.stop));

    p_commit_single_r6: assert property (@(posedge clk) disable iff (rst)
        commit_o |=> !commit_o);

endmodule

// File: tb/tb_eep_wr_slave.sv
module tb_eep_wr_slave;

    localparam logic [6:0] DEV = 7'h50;
    localparam int         QTR = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst;
    logic        scl_m;
    logic        sda_m;
    logic        wc;
    logic        busy;
    logic        sda_oe;
    logic        bvld;
    logic [15:0] baddr;
    logic [7:0]  bdata;
    logic        bwe;
    logic        commit;
    wire         sda_line = sda_m & ~sda_oe;

    eep_wr_slave dut (
        .clk          (clk),
        .rst          (rst),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .wc_i         (wc),
        .busy_i       (busy),
        .sda_oe_o     (sda_oe),
        .byte_valid_o (bvld),
        .byte_addr_o  (baddr),
        .byte_data_o  (bdata),
        .byte_we_o    (bwe),
        .commit_o     (commit)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [15:0] rec_a [0:15];
    logic [7:0]  rec_d [0:15];
    logic        rec_w [0:15];
    int          n_rec     = 0;
    int          n_commit  = 0;
    int          busy_viol = 0;
    logic        busy_prev = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (bvld) begin
                if (n_rec < 16) begin
                    rec_a[n_rec] = baddr;
                    rec_d[n_rec] = bdata;
                    rec_w[n_rec] = bwe;
                end
                n_rec++;
            end
            if (commit) n_commit++;
            if (busy && busy_prev && sda_oe) busy_viol++;
            busy_prev = busy;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic wait_q();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
        wait_q();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            sda_m = b[7-i]; wait_q();
            scl_m = 1'b1;   wait_q(); wait_q();
            scl_m = 1'b0;   wait_q();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack, output bit pre,
                             output bit rel);
        send_bits(b, 8);
        sda_m = 1'b1; wait_q();
        pre = sda_oe;
        scl_m = 1'b1; wait_q();
        ack = ~sda_line;
        wait_q();
        scl_m = 1'b0; wait_q();
        rel = sda_oe;
    endtask

    function automatic logic [15:0] exp_addr(input logic [15:0] a, input int k);
        logic [5:0] lo;
        lo = a[5:0] + 6'(k);
        return {a[15:6], lo};
    endfunction

    function automatic logic [7:0] exp_data(input logic [7:0] seed, input int k);
        return seed + 8'(k * 37);
    endfunction

    task automatic do_header(input logic [15:0] a);
        bit ack, pre, rel;
        send_byte({DEV, 1'b0}, ack, pre, rel);
        check(ack == 1'b1, "R1 devsel ack", 32'(ack), 1);
        send_byte(a[15:8], ack, pre, rel);
        check(ack == 1'b1, "R2 addr hi ack", 32'(ack), 1);
        send_byte(a[7:0], ack, pre, rel);
        check(ack == 1'b1, "R2 addr lo ack", 32'(ack), 1);
    endtask

    task automatic do_write(input logic [15:0] a, input int n, input logic [7:0] seed,
                            input bit wcv);
        bit ack, pre, rel;
        int rec0, com0;
        wc   = wcv;
        rec0 = n_rec;
        com0 = n_commit;
        bus_start();
        do_header(a);
        for (int k = 0; k < n; k++) begin
            send_byte(exp_data(seed, k), ack, pre, rel);
            if (wcv) begin
                check(ack == 1'b0, "R5 data nack", 32'(ack), 0);
            end else begin
                check(ack == 1'b1, "R4 data ack", 32'(ack), 1);
                check(pre == 1'b1, "R10 ack before 9th clock", 32'(pre), 1);
                check(rel == 1'b0, "R10 ack released", 32'(rel), 0);
            end
        end
        bus_stop();
        check(n_rec - rec0 == n, "R3 beat count", 32'(n_rec - rec0), 32'(n));
        for (int k = 0; k < n; k++) begin
            check(rec_a[(rec0 + k) % 16] == exp_addr(a, k), "R3 beat addr",
                  32'(rec_a[(rec0 + k) % 16]), 32'(exp_addr(a, k)));
            check(rec_d[(rec0 + k) % 16] == exp_data(seed, k), "R3 beat data",
                  32'(rec_d[(rec0 + k) % 16]), 32'(exp_data(seed, k)));
            check(rec_w[(rec0 + k) % 16] == !wcv, wcv ? "R5 we low" : "R4 we high",
                  32'(rec_w[(rec0 + k) % 16]), 32'(!wcv));
        end
        if (wcv)
            check(n_commit - com0 == 0, "R5 no commit", 32'(n_commit - com0), 0);
        else
            check(n_commit - com0 == 1, "R6 one commit", 32'(n_commit - com0), 1);
        n_rec = 0;
        wc = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        bit ack, pre, rel;
        int com0;
        logic [15:0] starts [0:3];
        starts[0] = 16'h0000;
        starts[1] = 16'h1234;
        starts[2] = 16'hABFE;
        starts[3] = 16'hFFFF;

        rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; wc = 1'b0; busy = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(sda_oe == 1'b0, "R11 reset oe", 32'(sda_oe), 0);
        check(bvld == 1'b0, "R11 reset valid", 32'(bvld), 0);
        check(commit == 1'b0, "R11 reset commit", 32'(commit), 0);

        // R1: every device select value
        for (int v = 0; v < 256; v++) begin
            bus_start();
            send_byte(8'(v), ack, pre, rel);
            check(ack == (8'(v) == {DEV, 1'b0}), "R1 devsel sweep", 32'(ack),
                  32'(8'(v) == {DEV, 1'b0}));
            bus_stop();
        end

        // R1: after a refused select, later bytes are refused too
        bus_start();
        send_byte({DEV, 1'b1}, ack, pre, rel);
        check(ack == 1'b0, "R1 read bit nack", 32'(ack), 0);
        send_byte({DEV, 1'b0}, ack, pre, rel);
        check(ack == 1'b0, "R1 idle until start", 32'(ack), 0);
        bus_stop();

        // R3..R6, R10: writes over lengths, start addresses and wc
        for (int w = 0; w < 2; w++) begin
            for (int s = 0; s < 4; s++) begin
                for (int n = 1; n <= 4; n++) begin
                    do_write(starts[s], n, 8'(s * 16 + n + w), w[0]);
                end
            end
        end

        // R7: stop after address bytes
        com0 = n_commit;
        bus_start();
        do_header(16'h0100);
        bus_stop();
        check(n_commit == com0, "R7 stop after address", 32'(n_commit - com0), 0);

        // R7: stop part way through a data byte
        com0 = n_commit;
        bus_start();
        do_header(16'h0200);
        send_byte(8'h5A, ack, pre, rel);
        check(ack == 1'b1, "R4 data ack", 32'(ack), 1);
        send_bits(8'h00, 3);
        bus_stop();
        check(n_commit == com0, "R7 stop mid byte", 32'(n_commit - com0), 0);
        n_rec = 0;

        // R8: repeated start after an acked data byte
        com0 = n_commit;
        bus_start();
        do_header(16'h0300);
        send_byte(8'hC3, ack, pre, rel);
        bus_start();
        check(n_commit == com0, "R8 no commit on restart", 32'(n_commit - com0), 0);
        n_rec = 0;
        do_header(16'h0440);
        send_byte(8'h77, ack, pre, rel);
        check(ack == 1'b1, "R8 new transfer ack", 32'(ack), 1);
        bus_stop();
        check(n_commit - com0 == 1, "R8 new transfer commit", 32'(n_commit - com0), 1);
        check(rec_a[0] == 16'h0440, "R8 new transfer addr", 32'(rec_a[0]), 32'h0440);
        n_rec = 0;

        // R9: busy keeps the target off the bus
        busy = 1'b1;
        repeat (4) @(negedge clk);
        bus_start();
        send_byte({DEV, 1'b0}, ack, pre, rel);
        check(ack == 1'b0, "R9 busy devsel nack", 32'(ack), 0);
        send_byte(8'h00, ack, pre, rel);
        bus_stop();
        check(busy_viol == 0, "R9 no drive while busy", 32'(busy_viol), 0);
        busy = 1'b0;
        repeat (4) @(negedge clk);
        do_write(16'h0010, 1, 8'h99, 1'b0);

        finish_run();
    end

endmodule